// File: doc/BRIEF.md
# ATA Sector Transfer Sequencer

This block is the drive-side controller that paces a multi-sector read. When a read opcode is written to the command register, it loads the number of sectors and raises busy. It then asks a media model to fetch the first sector. Each time the media model reports that a sector is now in the buffer, the sequencer drops busy and raises buffer-ready. In DMA mode it also raises the DMA request. Interrupts are raised at block boundaries: after every sector for single-sector and DMA reads, and after every `blk_size` sectors for multiple-block reads. The last sector of a command always raises an interrupt.

When the host has emptied the buffer, the sequencer takes one sector off the remaining count. If sectors remain, it requests the next one; otherwise the transfer ends. A media failure, or an opcode the block does not know, ends the command with the status error bit set, an error code loaded and an interrupt raised. A read of the status register acknowledges the interrupt.

The event inputs are single-cycle strobes with no back-pressure: a strobe presented while the sequencer is not in the matching state is dropped, not queued. The data path between the host and the buffer lies outside this block.

Top module: `ata_xfer_seq`

## Requirements
- R1: After reset, irq, dmarq, busy, buf_rdy, err_flag and next_sec are 0, err_code is 0x01 and sectors_left is 0.
- R2: A cycle with cmd_we high clears irq and dmarq. For a known opcode (0x20 single read, 0xC4 multiple-block read, 0xC8 DMA read), the following hold one cycle later: busy is 1, buf_rdy is 0, err_flag is 0, err_code is 0x01, sectors_left holds the loaded count and next_sec pulses.
- R3: A cmd_count of 0 on a known opcode loads 256 sectors.
- R4: For a multiple-block read, irq rises after sector k when k is a multiple of blk_size (latched at the command). For the other read opcodes, irq rises after every sector.
- R5: The final sector of a command always raises irq, even off a block boundary.
- R6: For opcode 0xC8, dmarq rises in the cycle after an accepted sec_buffered. dmarq never rises without that strobe.
- R7: An accepted buf_drained clears buf_rdy and dmarq, sets err_code to 0x01 and decrements sectors_left. If the new count is non-zero, busy returns to 1 and next_sec pulses; otherwise busy stays 0.
- R8: media_err while busy sets err_flag, loads err_code 0x80, raises irq, clears busy and ends the transfer.
- R9: An unknown opcode sets err_flag, loads err_code 0x04, raises irq and leaves busy at 0.
- R10: stat_rd clears irq on the next edge. An interrupt raised in the same cycle takes priority, and irq stays 1.
- R11: sec_buffered and media_err are ignored unless a transfer is active and busy. buf_drained is ignored unless buf_rdy is 1. In each case the outputs are left unchanged.
- R12: busy stays 1 from command acceptance until the sector is buffered. busy and buf_rdy are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_we | input | 1 | Command register write strobe |
| cmd_op | input | 8 | Opcode written with cmd_we |
| cmd_count | input | 8 | Sector count sampled with cmd_we (0 means 256) |
| blk_size | input | 8 | Sectors per interrupt for multiple-block reads (0 treated as 1) |
| stat_rd | input | 1 | Status register read strobe |
| sec_buffered | input | 1 | Media model: a sector has been placed in the buffer |
| buf_drained | input | 1 | Host has emptied the buffer |
| media_err | input | 1 | Media model: the current sector failed |
| irq | output | 1 | Interrupt request |
| dmarq | output | 1 | DMA request |
| busy | output | 1 | Status busy bit |
| buf_rdy | output | 1 | Status buffer-ready bit |
| err_flag | output | 1 | Status error bit |
| err_code | output | 8 | Error register |
| sectors_left | output | 9 | Sectors still to transfer |
| next_sec | output | 1 | One-cycle request to fetch the next sector |

## Verification
Each output is registered, so a fault in the internal state appears at the ports on the first clock edge that uses it. A wrong sectors-until-interrupt value causes a missing or extra irq at the first block boundary. A wrong remaining count shows up at once on sectors_left, and at the last drain as busy and next_sec with the wrong values. A lost active or busy flag makes the block accept strobes it should drop, which changes buf_rdy or err_code in the following cycle. The bench therefore samples every output after each strobe, with block sizes that both do and do not divide the count.

// File: rtl/ata_seq_pkg.sv
package ata_seq_pkg;
  localparam logic [7:0] OP_RD_SINGLE = 8'h20;
  localparam logic [7:0] OP_RD_MULTI  = 8'hC4;
  localparam logic [7:0] OP_RD_DMA    = 8'hC8;

  localparam logic [7:0] ERR_NONE  = 8'h01;
  localparam logic [7:0] ERR_ABORT = 8'h04;
  localparam logic [7:0] ERR_MEDIA = 8'h80;

  typedef struct packed {
    logic known;
    logic multi;
    logic dma;
  } cmd_kind_t;
endpackage

// File: rtl/ata_seq_decode.sv
module ata_seq_decode
  import ata_seq_pkg::*;
(
  input  logic [7:0] op,
  output cmd_kind_t  kind
);
  always_comb begin
    kind = '0;
    unique case (op)
      OP_RD_SINGLE: kind.known = 1'b1;
      OP_RD_MULTI:  begin kind.known = 1'b1; kind.multi = 1'b1; end
      OP_RD_DMA:    begin kind.known = 1'b1; kind.dma   = 1'b1; end
      default:      kind = '0;
    endcase
  end
endmodule

// File: rtl/ata_seq_irq_pacer.sv
module ata_seq_irq_pacer #(
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             multi,
  input  logic [BLK_W-1:0] blk_size,
  input  logic             sec_ok,
  input  logic             last_sec,
  input  logic             force_irq,
  input  logic             clr_cmd,
  input  logic             clr_rd,
  output logic             irq
);
  localparam logic [BLK_W-1:0] ONE = BLK_W'(1);

  logic [BLK_W-1:0] until_q;
  logic [BLK_W-1:0] blk_q;
  logic             multi_q;
  logic [BLK_W-1:0] start_blk;
  logic [BLK_W-1:0] reload;
  logic             fire;

  assign start_blk = (blk_size == '0) ? ONE : blk_size;
  assign reload    = multi_q ? blk_q : ONE;
  assign fire      = sec_ok && ((until_q == ONE) || last_sec);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      until_q <= ONE;
      blk_q   <= ONE;
      multi_q <= 1'b0;
    end else if (start) begin
      multi_q <= multi;
      blk_q   <= start_blk;
      until_q <= multi ? start_blk : ONE;
    end else if (sec_ok) begin
      until_q <= fire ? reload : until_q - ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 irq <= 1'b0;
    else if (fire || force_irq) irq <= 1'b1;
    else if (clr_cmd || clr_rd) irq <= 1'b0;
  end
endmodule

// File: rtl/ata_seq_xfer.sv
module ata_seq_xfer #(
  parameter int CNT_W  = 8,
  localparam int LEFT_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              start,
  input  logic              dma,
  input  logic [CNT_W-1:0]  cmd_count,
  input  logic              sec_buffered,
  input  logic              buf_drained,
  input  logic              media_err,
  output logic              busy,
  output logic              buf_rdy,
  output logic              dmarq,
  output logic              next_sec,
  output logic [LEFT_W-1:0] sectors_left,
  output logic              sec_ok,
  output logic              drain_ok,
  output logic              merr_ok,
  output logic              last_sec
);
  localparam logic [LEFT_W-1:0] ONE  = LEFT_W'(1);
  localparam logic [LEFT_W-1:0] FULL = ONE << CNT_W;

  logic active;
  logic dma_q;

  assign merr_ok  = !cmd_we && active && busy && media_err;
  assign sec_ok   = !cmd_we && active && busy && sec_buffered && !media_err;
  assign drain_ok = !cmd_we && active && buf_rdy && buf_drained;
  assign last_sec = (sectors_left == ONE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active       <= 1'b0;
      dma_q        <= 1'b0;
      busy         <= 1'b0;
      buf_rdy      <= 1'b0;
      dmarq        <= 1'b0;
      next_sec     <= 1'b0;
      sectors_left <= '0;
    end else begin
      next_sec <= 1'b0;
      if (cmd_we) begin
        dmarq   <= 1'b0;
        buf_rdy <= 1'b0;
        active  <= start;
        busy    <= start;
        if (start) begin
          dma_q        <= dma;
          next_sec     <= 1'b1;
          sectors_left <= (cmd_count == '0) ? FULL : {1'b0, cmd_count};
        end
      end else if (merr_ok) begin
        active  <= 1'b0;
        busy    <= 1'b0;
        buf_rdy <= 1'b0;
        dmarq   <= 1'b0;
      end else if (sec_ok) begin
        busy    <= 1'b0;
        buf_rdy <= 1'b1;
        dmarq   <= dma_q;
      end else if (drain_ok) begin
        buf_rdy      <= 1'b0;
        dmarq        <= 1'b0;
        sectors_left <= sectors_left - ONE;
        if (last_sec) begin
          active <= 1'b0;
        end else begin
          busy     <= 1'b1;
          next_sec <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ata_xfer_seq.sv
module ata_xfer_seq
  import ata_seq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int BLK_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [7:0]       cmd_op,
  input  logic [CNT_W-1:0] cmd_count,
  input  logic [BLK_W-1:0] blk_size,
  input  logic             stat_rd,
  input  logic             sec_buffered,
  input  logic             buf_drained,
  input  logic             media_err,
  output logic             irq,
  output logic             dmarq,
  output logic             busy,
  output logic             buf_rdy,
  output logic             err_flag,
  output logic [7:0]       err_code,
  output logic [CNT_W:0]   sectors_left,
  output logic             next_sec
);
  cmd_kind_t kind;
  logic start, sec_ok, drain_ok, merr_ok, last_sec, force_irq;

  ata_seq_decode u_dec (.op(cmd_op), .kind(kind));

  assign start     = cmd_we && kind.known;
  assign force_irq = (cmd_we && !kind.known) || merr_ok;

  ata_seq_xfer #(.CNT_W(CNT_W)) u_xfer (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .start(start), .dma(kind.dma),
    .cmd_count(cmd_count), .sec_buffered(sec_buffered), .buf_drained(buf_drained),
    .media_err(media_err), .busy(busy), .buf_rdy(buf_rdy), .dmarq(dmarq),
    .next_sec(next_sec), .sectors_left(sectors_left), .sec_ok(sec_ok),
    .drain_ok(drain_ok), .merr_ok(merr_ok), .last_sec(last_sec)
  );

  ata_seq_irq_pacer #(.BLK_W(BLK_W)) u_pace (
    .clk(clk), .rst_n(rst_n), .start(start), .multi(kind.multi),
    .blk_size(blk_size), .sec_ok(sec_ok), .last_sec(last_sec),
    .force_irq(force_irq), .clr_cmd(cmd_we), .clr_rd(stat_rd), .irq(irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_flag <= 1'b0;
      err_code <= ERR_NONE;
    end else if (cmd_we) begin
      err_flag <= !kind.known;
      err_code <= kind.known ? ERR_NONE : ERR_ABORT;
    end else if (merr_ok) begin
      err_flag <= 1'b1;
      err_code <= ERR_MEDIA;
    end else if (drain_ok) begin
      err_code <= ERR_NONE;
    end
  end
endmodule

// File: rtl/ata_xfer_seq_chk.sv
module ata_xfer_seq_chk
  import ata_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_we,
  input logic [7:0]     cmd_op,
  input logic [CNT_W-1:0] cmd_count,
  input logic           stat_rd,
  input logic           sec_buffered,
  input logic           buf_drained,
  input logic           media_err,
  input logic           irq,
  input logic           dmarq,
  input logic           busy,
  input logic           buf_rdy,
  input logic           err_flag,
  input logic [7:0]     err_code,
  input logic [CNT_W:0] sectors_left
);
  logic op_known;
  assign op_known = (cmd_op == OP_RD_SINGLE) || (cmd_op == OP_RD_MULTI) || (cmd_op == OP_RD_DMA);

  // R12
  busy_rdy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && buf_rdy));

  // R2
  cmd_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && op_known |=> busy && !irq && !dmarq && !err_flag);

  // R3
  cnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && op_known && (cmd_count == '0) |=> sectors_left == (CNT_W+1)'(1 << CNT_W));

  // R9
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !op_known |=> irq && err_flag && (err_code == ERR_ABORT) && !busy);

  // R8
  media_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    media_err && busy && !cmd_we |=> irq && err_flag && (err_code == ERR_MEDIA) && !busy);

  // R6
  dma_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dmarq) |-> $past(sec_buffered));

  // R10
  ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !cmd_we && !busy |=> !irq);

  // R11
  idle_sec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sec_buffered && !busy && !cmd_we && !buf_drained |=> $stable(buf_rdy));
endmodule

bind ata_xfer_seq ata_xfer_seq_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_count(cmd_count),
  .stat_rd(stat_rd), .sec_buffered(sec_buffered), .buf_drained(buf_drained),
  .media_err(media_err), .irq(irq), .dmarq(dmarq), .busy(busy), .buf_rdy(buf_rdy),
  .err_flag(err_flag), .err_code(err_code), .sectors_left(sectors_left)
);

// File: tb/test_ata_xfer_seq.sv
module test_ata_xfer_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_we = 1'b0;
  logic [7:0] cmd_op = '0;
  logic [7:0] cmd_count = '0;
  logic [7:0] blk_size = '0;
  logic       stat_rd = 1'b0;
  logic       sec_buffered = 1'b0;
  logic       buf_drained = 1'b0;
  logic       media_err = 1'b0;
  logic       irq, dmarq, busy, buf_rdy, err_flag, next_sec;
  logic [7:0] err_code;
  logic [8:0] sectors_left;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ata_xfer_seq i_ata_xfer_seq (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_op(cmd_op), .cmd_count(cmd_count),
    .blk_size(blk_size), .stat_rd(stat_rd), .sec_buffered(sec_buffered),
    .buf_drained(buf_drained), .media_err(media_err), .irq(irq), .dmarq(dmarq),
    .busy(busy), .buf_rdy(buf_rdy), .err_flag(err_flag), .err_code(err_code),
    .sectors_left(sectors_left), .next_sec(next_sec)
  );

  // {opcode, count, block size}
  localparam logic [23:0] VEC [0:5] = '{
    24'h20_03_00, 24'hC4_05_02, 24'hC4_03_08,
    24'hC8_02_00, 24'hC4_04_04, 24'hC8_01_00
  };

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // 0 sec_buffered, 1 buf_drained, 2 stat_rd, 3 media_err, 4 sec+stat together
  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: sec_buffered = 1'b1;
      1: buf_drained  = 1'b1;
      2: stat_rd      = 1'b1;
      3: media_err    = 1'b1;
      default: begin sec_buffered = 1'b1; stat_rd = 1'b1; end
    endcase
    @(negedge clk);
    sec_buffered = 1'b0; buf_drained = 1'b0; stat_rd = 1'b0; media_err = 1'b0;
  endtask

  task automatic issue(input logic [7:0] op, input logic [7:0] cnt, input logic [7:0] blk);
    @(negedge clk);
    cmd_we = 1'b1; cmd_op = op; cmd_count = cnt; blk_size = blk;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "irq", irq, 0);
    chk("R1", "dmarq", dmarq, 0);
    chk("R1", "busy", busy, 0);
    chk("R1", "buf_rdy", buf_rdy, 0);
    chk("R1", "err_flag", err_flag, 0);
    chk("R1", "err_code", err_code, 8'h01);
    chk("R1", "sectors_left", sectors_left, 0);

    for (int v = 0; v < 6; v++) begin
      logic [7:0] op, cnt, blk;
      bit multi, dma;
      int n, b;
      {op, cnt, blk} = VEC[v];
      multi = (op == 8'hC4);
      dma   = (op == 8'hC8);
      n = (cnt == 0) ? 256 : cnt;
      b = (blk == 0) ? 1 : blk;
      issue(op, cnt, blk);
      chk("R2", "busy", busy, 1);
      chk("R2", "irq", irq, 0);
      chk("R2", "err_code", err_code, 8'h01);
      chk("R2", "sectors_left", sectors_left, n);
      chk("R2", "next_sec", next_sec, 1);
      for (int k = 1; k <= n; k++) begin
        bit on_blk, exp_irq;
        on_blk  = multi ? ((k % b) == 0) : 1'b1;
        exp_irq = on_blk || (k == n);
        strobe(0);
        chk((on_blk || !exp_irq) ? "R4" : "R5", "irq", irq, exp_irq);
        chk("R12", "busy", busy, 0);
        chk("R12", "buf_rdy", buf_rdy, 1);
        chk("R6", "dmarq", dmarq, dma);
        strobe(2);
        chk("R10", "irq", irq, 0);
        strobe(1);
        chk("R7", "buf_rdy", buf_rdy, 0);
        chk("R7", "dmarq", dmarq, 0);
        chk("R7", "err_code", err_code, 8'h01);
        chk("R7", "sectors_left", sectors_left, n - k);
        chk("R7", "busy", busy, k < n);
        chk("R7", "next_sec", next_sec, k < n);
      end
    end

    // R3 zero count loads 256
    issue(8'h20, 8'h00, 8'h00);
    chk("R3", "sectors_left", sectors_left, 256);
    // R8 media failure while busy
    strobe(3);
    chk("R8", "err_flag", err_flag, 1);
    chk("R8", "err_code", err_code, 8'h80);
    chk("R8", "irq", irq, 1);
    chk("R8", "busy", busy, 0);
    // R11 strobes ignored when no transfer is active
    strobe(2);
    strobe(0);
    chk("R11", "buf_rdy", buf_rdy, 0);
    chk("R11", "irq", irq, 0);
    strobe(1);
    chk("R11", "sectors_left", sectors_left, 256);
    strobe(3);
    chk("R11", "err_code", err_code, 8'h80);
    chk("R11", "irq", irq, 0);
    // R9 unknown opcode
    issue(8'h55, 8'h01, 8'h00);
    chk("R9", "err_flag", err_flag, 1);
    chk("R9", "err_code", err_code, 8'h04);
    chk("R9", "irq", irq, 1);
    chk("R9", "busy", busy, 0);
    // R2 command write clears a pending irq
    issue(8'hC8, 8'h02, 8'h00);
    chk("R2", "irq", irq, 0);
    chk("R2", "err_flag", err_flag, 0);
    // R10 set and acknowledge in the same cycle: set wins
    strobe(4);
    chk("R10", "irq", irq, 1);
    chk("R6", "dmarq", dmarq, 1);
    // R2 command write drops dmarq and irq
    issue(8'hC8, 8'h02, 8'h00);
    chk("R2", "dmarq", dmarq, 0);
    chk("R2", "irq", irq, 0);
    // R11 drain ignored while buffer not ready
    strobe(1);
    chk("R11", "sectors_left", sectors_left, 2);
    chk("R12", "busy", busy, 1);

    summary();
  end
endmodule